// File: doc/BRIEF.md
# Double-Rate Burst SRAM Command Front End

This block is the synchronous control and storage core of a single-port SRAM with double-data-rate transfers. On each rising clock edge it samples four control inputs: an active-low chip select, a bank-hit flag, a continue flag and an active-low write flag. From these it decodes one of five commands: bank off, idle (deselect), read, write or continue. Each cycle moves two words. They travel on a rise lane and a fall lane, and each lane has its own output enable. An echo-clock enable tells the pad logic whether the echo clock should run.

The access address selects a word pair. The rise word sits at the even word address of the pair and the fall word at the odd one. A new read or write loads that pair as the burst base. The first continue moves to the next pair, which is two words further on. The next continue goes back to the base, so one address yields a burst of four words. Write data is late: it arrives on both lanes in the cycle after the command. Read data is pipelined: it leaves on both lanes in the cycle after the command. When a read directly follows a write to the same pair, the newly arriving write data is returned.

Top module: `ddr_burst_sram`

## Requirements
- R1: During and after a synchronous active-high reset, oeRise, oeFall and echoEn are 0. A continue issued straight after reset behaves as bank off.
- R2: advance=0 with bankHit=0 is bank off. In the next cycle oeRise=oeFall=0 and echoEn=0.
- R3: advance=0, bankHit=1, selN=1 is idle. In the next cycle oeRise=oeFall=0 and echoEn=1.
- R4: advance=0, bankHit=1, selN=0, writeN=1 is a read of pair pairIn. In the next cycle oeRise=oeFall=1, echoEn=1, dataRiseOut holds word {pair,0} and dataFallOut holds word {pair,1}.
- R5: advance=0, bankHit=1, selN=0, writeN=0 is a write of pair pairIn. The lanes dataRiseIn and dataFallIn in the following cycle are stored at words {pair,0} and {pair,1}. In the cycle after the command oeRise=oeFall=0 and echoEn=1.
- R6: advance=1 repeats the operation type of the previous cycle, and selN, bankHit, writeN and pairIn are ignored. Its outputs then equal those of the previous command type.
- R7: The first continue after a new read or write accesses pair base+1.
- R8: A second consecutive continue accesses the base pair again. Further continues keep alternating between base+1 and base.
- R9: A read of the pair written by the immediately preceding command returns the write data arriving in that same cycle.
- R10: Pair arithmetic wraps modulo 2^PAIR_W, so a continue from the last pair accesses pair 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| selN | input | 1 | Chip select, active low |
| bankHit | input | 1 | Bank-match flag (secondary enables equal their match values) |
| advance | input | 1 | Continue flag |
| writeN | input | 1 | 0 = write, 1 = read |
| pairIn | input | PAIR_W | Word-pair address of a new access |
| dataRiseIn | input | DATA_W | Write data, rise lane |
| dataFallIn | input | DATA_W | Write data, fall lane |
| dataRiseOut | output | DATA_W | Read data, rise lane |
| dataFallOut | output | DATA_W | Read data, fall lane |
| oeRise | output | 1 | Drive enable, rise lane |
| oeFall | output | 1 | Drive enable, fall lane |
| echoEn | output | 1 | Echo-clock enable |

## Verification
The embedded properties check the command decode against the enables on every cycle. Bank off kills the echo, while idle and write keep it and drop the data enables. A read raises both lane enables, and a continue leaves the enables unchanged. They also check that a read immediately after a write to the same pair returns the incoming lanes. Only the bench scenarios can show that stored data comes back from the right pair across a burst. That covers the step to base+1, the return to base on the second continue, the wrap from the top pair to pair 0, and late-write data landing where the scoreboard model expects it.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_BANKOFF = 2'd0,
    OP_IDLE    = 2'd1,
    OP_READ    = 2'd2,
    OP_WRITE   = 2'd3
  } op_t;

  // strobes from control to datapath for the current cycle
  typedef struct packed {
    logic rdStb;
    logic wrStb;
  } strobe_t;

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int PAIR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selN,
  input  logic              bankHit,
  input  logic              advance,
  input  logic              writeN,
  input  logic [PAIR_W-1:0] pairIn,
  output strobe_t           stb,
  output logic [PAIR_W-1:0] pairAddr,
  output logic              oeRise,
  output logic              oeFall,
  output logic              echoEn
);

  op_t               lastOp, nextOp;
  logic [PAIR_W-1:0] basePair, nextBase;
  logic              stepOdd, nextStep;

  // command decode and burst address generation
  always_comb begin
    nextOp   = lastOp;
    nextBase = basePair;
    nextStep = stepOdd;
    if (advance) begin
      nextStep = ~stepOdd;
    end else if (!bankHit) begin
      nextOp = OP_BANKOFF;
    end else if (selN) begin
      nextOp = OP_IDLE;
    end else begin
      nextOp   = writeN ? OP_READ : OP_WRITE;
      nextBase = pairIn;
      nextStep = 1'b0;
    end
    pairAddr  = nextBase + PAIR_W'(nextStep);
    stb.rdStb = (nextOp == OP_READ);
    stb.wrStb = (nextOp == OP_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastOp   <= OP_BANKOFF;
      basePair <= '0;
      stepOdd  <= 1'b0;
      oeRise   <= 1'b0;
      oeFall   <= 1'b0;
      echoEn   <= 1'b0;
    end else begin
      lastOp   <= nextOp;
      basePair <= nextBase;
      stepOdd  <= nextStep;
      oeRise   <= (nextOp == OP_READ);
      oeFall   <= (nextOp == OP_READ);
      echoEn   <= (nextOp != OP_BANKOFF);
    end
  end

  assert_bankoff_R2: assert property (@(posedge clk) disable iff (rst)
    (!advance && !bankHit) |=> (!echoEn && !oeRise && !oeFall));

  assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!advance && bankHit && selN) |=> (echoEn && !oeRise && !oeFall));

  assert_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!advance && bankHit && !selN && writeN) |=> (echoEn && oeRise && oeFall));

  assert_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!advance && bankHit && !selN && !writeN) |=> (echoEn && !oeRise && !oeFall));

  assert_continue_R6: assert property (@(posedge clk) disable iff (rst)
    advance |=> ($stable(oeRise) && $stable(oeFall) && $stable(echoEn)));

endmodule

// File: rtl/burst_sram_dpath.sv
module burst_sram_dpath
  import burst_sram_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int PAIR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [PAIR_W-1:0] pairAddr,
  input  logic [DATA_W-1:0] dataRiseIn,
  input  logic [DATA_W-1:0] dataFallIn,
  output logic [DATA_W-1:0] dataRiseOut,
  output logic [DATA_W-1:0] dataFallOut
);

  localparam int PAIRS = 2 ** PAIR_W;

  logic              wrPend;
  logic [PAIR_W-1:0] wrPair;
  logic [DATA_W-1:0] laneIn  [2];
  logic [DATA_W-1:0] laneOut [2];
  logic              hitPend;

  assign laneIn[0]   = dataRiseIn;
  assign laneIn[1]   = dataFallIn;
  assign dataRiseOut = laneOut[0];
  assign dataFallOut = laneOut[1];
  assign hitPend     = wrPend && (wrPair == pairAddr);

  // late write: remember the pair, take the data one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      wrPend <= 1'b0;
      wrPair <= '0;
    end else begin
      wrPend <= stb.wrStb;
      wrPair <= pairAddr;
    end
  end

  // one storage bank per phase lane (word address low bit = lane)
  for (genvar ph = 0; ph < 2; ph++) begin : g_lane
    logic [DATA_W-1:0] bank [PAIRS];

    always_ff @(posedge clk) begin
      if (wrPend) bank[wrPair] <= laneIn[ph];
    end

    always_ff @(posedge clk) begin
      if (rst)            laneOut[ph] <= '0;
      else if (stb.rdStb) laneOut[ph] <= hitPend ? laneIn[ph] : bank[pairAddr];
    end

    assert_forward_R9: assert property (@(posedge clk) disable iff (rst)
      (stb.rdStb && wrPend && (wrPair == pairAddr)) |=> (laneOut[ph] == $past(laneIn[ph])));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !stb.rdStb |=> $stable(laneOut[ph]));
  end

endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
  import burst_sram_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int PAIR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selN,
  input  logic              bankHit,
  input  logic              advance,
  input  logic              writeN,
  input  logic [PAIR_W-1:0] pairIn,
  input  logic [DATA_W-1:0] dataRiseIn,
  input  logic [DATA_W-1:0] dataFallIn,
  output logic [DATA_W-1:0] dataRiseOut,
  output logic [DATA_W-1:0] dataFallOut,
  output logic              oeRise,
  output logic              oeFall,
  output logic              echoEn
);

  strobe_t           stb;
  logic [PAIR_W-1:0] pairAddr;

  burst_sram_ctrl #(.PAIR_W(PAIR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .selN     (selN),
    .bankHit  (bankHit),
    .advance  (advance),
    .writeN   (writeN),
    .pairIn   (pairIn),
    .stb      (stb),
    .pairAddr (pairAddr),
    .oeRise   (oeRise),
    .oeFall   (oeFall),
    .echoEn   (echoEn)
  );

  burst_sram_dpath #(.DATA_W(DATA_W), .PAIR_W(PAIR_W)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .pairAddr    (pairAddr),
    .dataRiseIn  (dataRiseIn),
    .dataFallIn  (dataFallIn),
    .dataRiseOut (dataRiseOut),
    .dataFallOut (dataFallOut)
  );

endmodule

// File: tb/sim_ddr_burst_sram.sv
module sim_ddr_burst_sram;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        selN = 1'b1, bankHit = 1'b0, advance = 1'b0, writeN = 1'b1;
  logic [4:0]  pairIn = '0;
  logic [35:0] dataRiseIn = '0, dataFallIn = '0;
  logic [35:0] dataRiseOut, dataFallOut;
  logic        oeRise, oeFall, echoEn;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  ddr_burst_sram u0 (
    .clk(clk), .rst(rst), .selN(selN), .bankHit(bankHit), .advance(advance),
    .writeN(writeN), .pairIn(pairIn), .dataRiseIn(dataRiseIn), .dataFallIn(dataFallIn),
    .dataRiseOut(dataRiseOut), .dataFallOut(dataFallOut),
    .oeRise(oeRise), .oeFall(oeFall), .echoEn(echoEn)
  );

  typedef struct {
    logic        oe;
    logic        echo;
    logic        rd;
    logic [35:0] rise;
    logic [35:0] fall;
    string       tag;
  } exp_t;

  exp_t q[$];

  // reference model, built from the requirements
  logic [35:0] mem [64];
  int          mOp = 0;        // 0 bank off, 1 idle, 2 read, 3 write
  logic [4:0]  mBase = '0;
  logic        mStep = 1'b0;
  logic        mPend = 1'b0;
  logic [4:0]  mPendPair = '0;
  logic [31:0] seq = '0;

  task automatic check(input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one command per cycle, pushes the expected outcome
  task automatic cyc(input logic adv, input logic hit, input logic sN,
                     input logic wN, input logic [4:0] p, input string tag);
    exp_t        e;
    logic [35:0] dR, dF;
    logic [4:0]  cur;
    seq++;
    dR = {4'hA, seq};
    dF = {4'h5, seq ^ 32'hFFFF_0000};
    advance = adv; bankHit = hit; selN = sN; writeN = wN; pairIn = p;
    dataRiseIn = dR; dataFallIn = dF;
    if (mPend) begin
      mem[{mPendPair, 1'b0}] = dR;
      mem[{mPendPair, 1'b1}] = dF;
      mPend = 1'b0;
    end
    if (adv) begin
      mStep = ~mStep;
    end else if (!hit) begin
      mOp = 0;
    end else if (sN) begin
      mOp = 1;
    end else begin
      mOp   = wN ? 2 : 3;
      mBase = p;
      mStep = 1'b0;
    end
    cur = mBase + {4'd0, mStep};
    if (mOp == 3) begin
      mPend = 1'b1;
      mPendPair = cur;
    end
    e.oe   = (mOp == 2);
    e.echo = (mOp != 0);
    e.rd   = (mOp == 2);
    e.rise = mem[{cur, 1'b0}];
    e.fall = mem[{cur, 1'b1}];
    e.tag  = tag;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: compares each result just after the edge that produced it
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (!rst && q.size() > 0) begin
      e = q.pop_front();
      check(e.tag, "oeRise", {35'd0, oeRise}, {35'd0, e.oe});
      check(e.tag, "oeFall", {35'd0, oeFall}, {35'd0, e.oe});
      check(e.tag, "echoEn", {35'd0, echoEn}, {35'd0, e.echo});
      if (e.rd) begin
        check(e.tag, "dataRiseOut", dataRiseOut, e.rise);
        check(e.tag, "dataFallOut", dataFallOut, e.fall);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: enables are off straight out of reset
    check("R1", "oeRise", {35'd0, oeRise}, 36'd0);
    check("R1", "oeFall", {35'd0, oeFall}, 36'd0);
    check("R1", "echoEn", {35'd0, echoEn}, 36'd0);
    cyc(1, 1, 0, 0, 5'd3, "R1");        // continue after reset = bank off

    // write burst at pair 4: 4, 5, back to 4
    cyc(0, 1, 0, 0, 5'd4, "R5");
    cyc(1, 0, 1, 1, 5'd20, "R7");
    cyc(1, 1, 1, 0, 5'd21, "R8");
    cyc(0, 1, 1, 1, 5'd0, "R3");        // idle, carries last write data
    cyc(1, 0, 0, 0, 5'd7, "R6");        // continue of idle, junk inputs

    // read burst at pair 4 with alternating continues
    cyc(0, 1, 0, 1, 5'd4, "R4");
    cyc(1, 1, 0, 0, 5'd9, "R7");
    cyc(1, 0, 1, 0, 5'd1, "R8");
    cyc(1, 1, 1, 1, 5'd2, "R7");

    // bank off, then continue with junk
    cyc(0, 0, 0, 1, 5'd2, "R2");
    cyc(1, 1, 0, 1, 5'd9, "R6");

    // wrap from the top pair
    cyc(0, 1, 0, 0, 5'd31, "R5");
    cyc(1, 0, 0, 1, 5'd3, "R10");
    cyc(0, 1, 0, 1, 5'd31, "R4");
    cyc(1, 0, 1, 0, 5'd8, "R10");
    cyc(1, 1, 0, 0, 5'd8, "R8");

    // read directly after write to the same pair
    cyc(0, 1, 0, 0, 5'd9, "R5");
    cyc(0, 1, 0, 1, 5'd9, "R9");
    cyc(0, 1, 0, 0, 5'd12, "R5");
    cyc(1, 0, 0, 1, 5'd0, "R7");
    cyc(0, 1, 0, 1, 5'd13, "R9");
    cyc(0, 1, 0, 1, 5'd12, "R4");
    cyc(1, 0, 1, 0, 5'd0, "R6");        // continue of read stays a read
    cyc(0, 1, 1, 0, 5'd0, "R3");
    cyc(0, 0, 1, 1, 5'd0, "R2");

    repeat (3) @(posedge clk);
    #3;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard actual=%0d left expected=0 left", q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule